// File: doc/BRIEF.md
# Dual-Bus Synchronous SRAM with Port-to-Port Streaming

This block is a single memory array with two 9-bit data buses around it: a processor-side bus and a system-side bus. Each bus has three parts: an input register loaded on the rising clock edge, an output latch that is transparent while the clock is high and holds while it is low, and an output enable that acts without a clock. The address is taken on the falling edge. The write strobe and the two per-bus input enables are taken on the rising edge. The write commits at the falling edge that closes the cycle.

In every cycle, each bus's output latch has one of two sources. If the opposite bus had its input enable asserted, the latch streams that bus's freshly registered input word. Otherwise it shows the array word at the registered address. This lets data pass from one bus to the other in either direction, with or without a write to the array in the same cycle. The block can also act as a separate-I/O memory. To do so, hold the system input enable and the processor output enable inactive and drive the processor input enable together with the write strobe. The processor bus then carries write data, and the system bus carries read data under its own output enable.

Each bidirectional bus is modelled as three signals: a data input, a data output and a drive enable. The depth is a parameter. The full 128K-word part uses an address width of 17. The default is kept small for elaboration.

Top module: `dualbus_sram`

## Requirements
- R1: The address that is present at a falling clock edge selects the word for the cycle that begins at the next rising edge. A change to the address after that falling edge has no effect on that cycle.
- R2: The write strobe, both input enables and both data buses are taken at the rising edge. Changes to them later in the same clock period have no effect on that cycle's outputs or on its write.
- R3: All control inputs are active low. When the write strobe is low, the array word at the registered address is written from the bus whose input enable is low. The processor bus wins when both input enables are low. If neither input enable is low, nothing is written.
- R4: When neither input enable is low, both output latches show the array word at the registered address. This word is the value before any write of that same cycle.
- R5: When one bus's input enable is low, the other bus's output latch shows the word registered from that bus. This works in both directions, and in both directions at once.
- R6: Streaming and a write to the array can happen in the same cycle. The streamed word appears on the opposite bus, and later reads return the written word.
- R7: Each output latch follows its source while the clock is high and holds the value it had at the falling edge while the clock is low. This holds even though the address register reloads at that edge.
- R8: An output enable that is high immediately lowers its bus's drive enable and forces that bus's data output to zero. The output returns as soon as the enable goes low again, with no clock edge needed.
- R9: While the synchronous, active-high reset is asserted, no write reaches the array, and both data outputs read zero during the low clock phase.
- R10: In separate-I/O use, the processor bus's drive enable stays low. A write streams its word onto the system bus, and a later read of that address returns the word on the system bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock: address on the falling edge, controls and data on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | Word address |
| wr_n_i | input | 1 | Write strobe, active low |
| cpu_in_en_n_i | input | 1 | Processor bus input enable, active low |
| sys_in_en_n_i | input | 1 | System bus input enable, active low |
| cpu_out_en_n_i | input | 1 | Processor bus output enable, active low, asynchronous |
| sys_out_en_n_i | input | 1 | System bus output enable, active low, asynchronous |
| cpu_d_i | input | DATA_W | Processor bus data in (8 data bits and 1 parity bit) |
| cpu_q_o | output | DATA_W | Processor bus data out, zero when not driven |
| cpu_oe_o | output | 1 | Processor bus drive enable |
| sys_d_i | input | DATA_W | System bus data in |
| sys_q_o | output | DATA_W | System bus data out, zero when not driven |
| sys_oe_o | output | 1 | System bus drive enable |

## Verification
The bench builds the block with a 9-bit word and a 5-bit address, which gives 32 words. With this depth the bench can fill every word with a distinct value before the directed work starts. It also puts the top address, 31, and address 0 within a few cycles of each other, so the boundary words are exercised alongside the middle ones. Because every word has a known, unique content, any streamed value, wrong-address read or misrouted write shows up as a mismatch against the bench's own copy of the array.

// File: rtl/dualbus_sram_pkg.sv
package dualbus_sram_pkg;
  localparam int unsigned NPORT    = 2;
  localparam int unsigned PORT_CPU = 0;
  localparam int unsigned PORT_SYS = 1;

  typedef enum logic {
    SRC_ARRAY = 1'b0,
    SRC_PEER  = 1'b1
  } latch_src_e;
endpackage

// File: rtl/dualbus_sram_addr_stage.sv
module dualbus_sram_addr_stage #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_q_o
);
  // falling-edge capture: the word is selected half a period ahead of the controls
  always_ff @(negedge clk) begin
    if (rst) addr_q_o <= '0;
    else     addr_q_o <= addr_i;
  end
endmodule

// File: rtl/dualbus_sram_array.sv
module dualbus_sram_array #(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // commit at the falling edge that closes the cycle; the read during the
  // high phase therefore still sees the previous contents
  always_ff @(negedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/dualbus_sram_port.sv
module dualbus_sram_port
  import dualbus_sram_pkg::*;
#(
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] d_i,
  input  logic              in_en_n_i,
  input  logic              out_en_n_i,
  input  logic [DATA_W-1:0] peer_data_i,
  input  logic              peer_take_i,
  input  logic [DATA_W-1:0] array_rd_i,
  output logic [DATA_W-1:0] din_q_o,
  output logic              take_o,
  output logic [DATA_W-1:0] q_o,
  output logic              oe_o
);
  latch_src_e        src;
  logic [DATA_W-1:0] live;
  logic [DATA_W-1:0] held;

  // rising-edge input register and registered input enable
  always_ff @(posedge clk) begin
    if (rst) begin
      din_q_o <= '0;
      take_o  <= 1'b0;
    end else begin
      din_q_o <= d_i;
      take_o  <= ~in_en_n_i;
    end
  end

  assign src  = peer_take_i ? SRC_PEER : SRC_ARRAY;
  assign live = (src == SRC_PEER) ? peer_data_i : array_rd_i;

  // low-phase hold register
  always_ff @(negedge clk) begin
    if (rst) held <= '0;
    else     held <= live;
  end

  assign oe_o = ~out_en_n_i;
  assign q_o  = oe_o ? (clk ? live : held) : '0;
endmodule

// File: rtl/dualbus_sram.sv
module dualbus_sram
  import dualbus_sram_pkg::*;
#(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_n_i,
  input  logic              cpu_in_en_n_i,
  input  logic              sys_in_en_n_i,
  input  logic              cpu_out_en_n_i,
  input  logic              sys_out_en_n_i,
  input  logic [DATA_W-1:0] cpu_d_i,
  output logic [DATA_W-1:0] cpu_q_o,
  output logic              cpu_oe_o,
  input  logic [DATA_W-1:0] sys_d_i,
  output logic [DATA_W-1:0] sys_q_o,
  output logic              sys_oe_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [DATA_W-1:0] rdata;
  logic              we;
  logic [DATA_W-1:0] wdata;

  logic [DATA_W-1:0] pin_d    [NPORT];
  logic              pin_ie_n [NPORT];
  logic              pin_oe_n [NPORT];
  logic [DATA_W-1:0] din_q    [NPORT];
  logic              take     [NPORT];
  logic [DATA_W-1:0] pq       [NPORT];
  logic              poe      [NPORT];

  assign pin_d[PORT_CPU]    = cpu_d_i;
  assign pin_d[PORT_SYS]    = sys_d_i;
  assign pin_ie_n[PORT_CPU] = cpu_in_en_n_i;
  assign pin_ie_n[PORT_SYS] = sys_in_en_n_i;
  assign pin_oe_n[PORT_CPU] = cpu_out_en_n_i;
  assign pin_oe_n[PORT_SYS] = sys_out_en_n_i;

  dualbus_sram_addr_stage #(.ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .addr_i   (addr_i),
    .addr_q_o (addr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) wr_q <= 1'b0;
    else     wr_q <= ~wr_n_i;
  end

  // write source arbitration: processor bus first
  always_comb begin
    we    = 1'b0;
    wdata = din_q[PORT_SYS];
    if (wr_q) begin
      if (take[PORT_CPU]) begin
        we    = 1'b1;
        wdata = din_q[PORT_CPU];
      end else if (take[PORT_SYS]) begin
        we    = 1'b1;
      end
    end
  end

  dualbus_sram_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
    .clk     (clk),
    .we_i    (we),
    .addr_i  (addr_q),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam int unsigned PEER = NPORT - 1 - p;
    dualbus_sram_port #(.DATA_W(DATA_W)) u_port (
      .clk         (clk),
      .rst         (rst),
      .d_i         (pin_d[p]),
      .in_en_n_i   (pin_ie_n[p]),
      .out_en_n_i  (pin_oe_n[p]),
      .peer_data_i (din_q[PEER]),
      .peer_take_i (take[PEER]),
      .array_rd_i  (rdata),
      .din_q_o     (din_q[p]),
      .take_o      (take[p]),
      .q_o         (pq[p]),
      .oe_o        (poe[p])
    );
  end

  assign cpu_q_o  = pq[PORT_CPU];
  assign cpu_oe_o = poe[PORT_CPU];
  assign sys_q_o  = pq[PORT_SYS];
  assign sys_oe_o = poe[PORT_SYS];
endmodule

// File: rtl/dualbus_sram_checker.sv
module dualbus_sram_checker #(
  parameter int unsigned DATA_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_in_en_n_i,
  input logic              sys_in_en_n_i,
  input logic              cpu_out_en_n_i,
  input logic              sys_out_en_n_i,
  input logic [DATA_W-1:0] cpu_d_i,
  input logic [DATA_W-1:0] sys_d_i,
  input logic [DATA_W-1:0] cpu_q_o,
  input logic [DATA_W-1:0] sys_q_o,
  input logic              cpu_oe_o,
  input logic              sys_oe_o
);
  // R5: a system-bus word taken at a rising edge is what the processor bus holds by the next one
  a_r5_stream_to_cpu: assert property (@(posedge clk) disable iff (rst)
    !sys_in_en_n_i |=> (cpu_out_en_n_i || cpu_q_o == $past(sys_d_i)));

  // R5: the same in the other direction
  a_r5_stream_to_sys: assert property (@(posedge clk) disable iff (rst)
    !cpu_in_en_n_i |=> (sys_out_en_n_i || sys_q_o == $past(cpu_d_i)));

  // R8: an undriven bus carries zero
  a_r8_cpu_gated: assert property (@(posedge clk) disable iff (rst)
    !cpu_oe_o |-> (cpu_q_o == '0));

  // R8: the same on the system bus
  a_r8_sys_gated: assert property (@(posedge clk) disable iff (rst)
    !sys_oe_o |-> (sys_q_o == '0));
endmodule

bind dualbus_sram dualbus_sram_checker #(.DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .cpu_in_en_n_i  (cpu_in_en_n_i),
  .sys_in_en_n_i  (sys_in_en_n_i),
  .cpu_out_en_n_i (cpu_out_en_n_i),
  .sys_out_en_n_i (sys_out_en_n_i),
  .cpu_d_i        (cpu_d_i),
  .sys_d_i        (sys_d_i),
  .cpu_q_o        (cpu_q_o),
  .sys_q_o        (sys_q_o),
  .cpu_oe_o       (cpu_oe_o),
  .sys_oe_o       (sys_oe_o)
);

// File: tb/dualbus_sram_tb_top.sv
module dualbus_sram_tb_top;
  localparam int unsigned DW    = 9;
  localparam int unsigned AW    = 5;
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned NVEC  = 15;

  // vector: {addr[4:0], wr_n, cpu_ie_n, sys_ie_n, cpu_d[8:0], sys_d[8:0]}
  localparam logic [25:0] VECS [NVEC] = '{
    {5'd3,  3'b111, 9'h000, 9'h000},
    {5'd4,  3'b010, 9'h000, 9'h1F0},
    {5'd4,  3'b111, 9'h000, 9'h000},
    {5'd5,  3'b000, 9'h0AA, 9'h155},
    {5'd5,  3'b111, 9'h000, 9'h000},
    {5'd6,  3'b101, 9'h123, 9'h000},
    {5'd6,  3'b111, 9'h000, 9'h000},
    {5'd7,  3'b110, 9'h000, 9'h0F0},
    {5'd7,  3'b111, 9'h000, 9'h000},
    {5'd8,  3'b100, 9'h03C, 9'h1C3},
    {5'd31, 3'b001, 9'h1FF, 9'h000},
    {5'd31, 3'b111, 9'h000, 9'h000},
    {5'd0,  3'b111, 9'h000, 9'h000},
    {5'd9,  3'b011, 9'h0E7, 9'h018},
    {5'd9,  3'b111, 9'h000, 9'h000}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic          wr_n_i = 1'b1;
  logic          cpu_in_en_n_i = 1'b1;
  logic          sys_in_en_n_i = 1'b1;
  logic          cpu_out_en_n_i = 1'b0;
  logic          sys_out_en_n_i = 1'b0;
  logic [DW-1:0] cpu_d_i = '0;
  logic [DW-1:0] sys_d_i = '0;
  logic [DW-1:0] cpu_q_o, sys_q_o;
  logic          cpu_oe_o, sys_oe_o;

  int errors = 0;
  int checks = 0;
  logic [DW-1:0] ref_mem [DEPTH];

  always #5 clk = ~clk;

  dualbus_sram #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .addr_i(addr_i), .wr_n_i(wr_n_i),
    .cpu_in_en_n_i(cpu_in_en_n_i), .sys_in_en_n_i(sys_in_en_n_i),
    .cpu_out_en_n_i(cpu_out_en_n_i), .sys_out_en_n_i(sys_out_en_n_i),
    .cpu_d_i(cpu_d_i), .cpu_q_o(cpu_q_o), .cpu_oe_o(cpu_oe_o),
    .sys_d_i(sys_d_i), .sys_q_o(sys_q_o), .sys_oe_o(sys_oe_o)
  );

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // one operation: address before the falling edge, controls before the rising edge,
  // samples in the high phase, after late input changes, and in the low phase
  task automatic op(input logic [AW-1:0] a, input logic w, input logic c, input logic s,
                    input logic [DW-1:0] cd, input logic [DW-1:0] sd,
                    output logic [DW-1:0] hc, output logic [DW-1:0] hs,
                    output logic [DW-1:0] rc, output logic [DW-1:0] rs,
                    output logic [DW-1:0] lc, output logic [DW-1:0] ls);
    @(posedge clk); #1 addr_i = a;
    @(negedge clk); #1;
    wr_n_i = w; cpu_in_en_n_i = c; sys_in_en_n_i = s; cpu_d_i = cd; sys_d_i = sd;
    @(posedge clk); #2;
    hc = cpu_q_o; hs = sys_q_o;
    #1;
    wr_n_i = 1'b1; cpu_in_en_n_i = 1'b1; sys_in_en_n_i = 1'b1;
    cpu_d_i = ~cd; sys_d_i = ~sd; addr_i = ~a;
    #1;
    rc = cpu_q_o; rs = sys_q_o;
    @(negedge clk); #2;
    lc = cpu_q_o; ls = sys_q_o;
  endtask

  // apply the bench's own model of the requirements to one operation
  task automatic model(input logic [AW-1:0] a, input logic w, input logic c, input logic s,
                       input logic [DW-1:0] cd, input logic [DW-1:0] sd,
                       output logic [DW-1:0] ec, output logic [DW-1:0] es);
    ec = (s == 1'b0) ? sd : ref_mem[a];
    es = (c == 1'b0) ? cd : ref_mem[a];
    if (w == 1'b0) begin
      if (c == 1'b0)      ref_mem[a] = cd;
      else if (s == 1'b0) ref_mem[a] = sd;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] hc, hs, rc, rs, lc, ls, ec, es;
    logic          prev_w;

    // R9: reset state seen in the low phase
    repeat (2) @(posedge clk);
    @(negedge clk); #2;
    chk("R9 cpu reset low phase", cpu_q_o, '0);
    chk("R9 sys reset low phase", sys_q_o, '0);
    @(posedge clk); #1 rst = 1'b0;

    // fill every word through the processor bus
    for (int i = 0; i < DEPTH; i++) begin
      logic [DW-1:0] v;
      v = DW'((i * 37 + 5) & 9'h1FF);
      op(AW'(i), 1'b0, 1'b0, 1'b1, v, '0, hc, hs, rc, rs, lc, ls);
      model(AW'(i), 1'b0, 1'b0, 1'b1, v, '0, ec, es);
    end

    // table walk
    prev_w = 1'b1;
    for (int k = 0; k < NVEC; k++) begin
      logic [AW-1:0] a;
      logic w, c, s;
      logic [DW-1:0] cd, sd;
      string tc, ts;
      {a, w, c, s, cd, sd} = VECS[k];
      op(a, w, c, s, cd, sd, hc, hs, rc, rs, lc, ls);
      model(a, w, c, s, cd, sd, ec, es);
      if (w == 1'b0)        begin tc = "R6"; ts = "R6"; end
      else if (prev_w == 1'b0) begin tc = "R3"; ts = "R3"; end
      else begin
        tc = (s == 1'b0) ? "R5" : "R4";
        ts = (c == 1'b0) ? "R5" : "R4";
      end
      chk({tc, " cpu high phase"}, hc, ec);
      chk({ts, " sys high phase"}, hs, es);
      chk("R2 cpu after late input change", rc, ec);
      chk("R2 sys after late input change", rs, es);
      chk("R7 cpu low phase hold", lc, ec);
      chk("R7 sys low phase hold", ls, es);
      prev_w = w;
    end

    // R1: the address present at the falling edge wins
    @(posedge clk); #1 addr_i = 5'd10;
    #2 addr_i = 5'd11;
    @(negedge clk); #2 addr_i = 5'd12;
    @(posedge clk); #2;
    chk("R1 cpu address at falling edge", cpu_q_o, ref_mem[11]);
    chk("R1 sys address at falling edge", sys_q_o, ref_mem[11]);

    // R8: output enables act mid-phase without a clock
    op(5'd13, 1'b1, 1'b1, 1'b1, '0, '0, hc, hs, rc, rs, lc, ls);
    @(posedge clk); #1 addr_i = 5'd13;
    @(posedge clk); #1 sys_out_en_n_i = 1'b1; cpu_out_en_n_i = 1'b1;
    #1;
    chk("R8 sys drive enable off", {8'd0, sys_oe_o}, '0);
    chk("R8 sys data forced zero", sys_q_o, '0);
    chk("R8 cpu data forced zero", cpu_q_o, '0);
    sys_out_en_n_i = 1'b0; cpu_out_en_n_i = 1'b0;
    #1;
    chk("R8 sys data restored", sys_q_o, ref_mem[13]);
    chk("R8 cpu data restored", cpu_q_o, ref_mem[13]);

    // R10: separate-I/O use
    cpu_out_en_n_i = 1'b1;
    op(5'd14, 1'b0, 1'b0, 1'b1, 9'h1C3, 9'h0, hc, hs, rc, rs, lc, ls);
    model(5'd14, 1'b0, 1'b0, 1'b1, 9'h1C3, 9'h0, ec, es);
    chk("R10 sys shows written word", hs, 9'h1C3);
    chk("R10 cpu bus undriven", {8'd0, cpu_oe_o}, '0);
    chk("R10 cpu data zero", hc, '0);
    op(5'd14, 1'b1, 1'b1, 1'b1, '0, '0, hc, hs, rc, rs, lc, ls);
    chk("R10 sys read back", hs, 9'h1C3);
    cpu_out_en_n_i = 1'b0;

    // R9: a write held during reset reaches nothing
    @(posedge clk); #1;
    rst = 1'b1; addr_i = 5'd2; wr_n_i = 1'b0; cpu_in_en_n_i = 1'b0; cpu_d_i = 9'h000;
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    chk("R9 cpu zero in reset", cpu_q_o, '0);
    chk("R9 sys zero in reset", sys_q_o, '0);
    @(posedge clk); #1;
    rst = 1'b0; wr_n_i = 1'b1; cpu_in_en_n_i = 1'b1;
    op(5'd2, 1'b1, 1'b1, 1'b1, '0, '0, hc, hs, rc, rs, lc, ls);
    chk("R9 word untouched by reset write", hc, ref_mem[2]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule